// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block turns simple operation requests into the strobe-level traffic of an asynchronous 8-bit NAND flash device. A requester hands over an operation code, a column, a row and a byte count in one valid/ready transfer. The sequencer then frames the command and address bytes and moves data bytes over the flash I/O lines. For reads the data leaves through a valid/ready stream, and for program loads it arrives through one. When a program is committed, the sequencer waits for the array to finish, fetches the status byte and reports pass or fail.

A read of a page is split into a page-open request, which waits out the array transfer, and any number of column-jump requests that continue reading from a new column without another wait. A program follows the same pattern: a page-open load, any number of column-jump loads, and one commit.

The flash I/O bus appears as separate input, output and output-enable vectors, so the pad ring can build the bidirectional pin. The sequencer starts no strobe while the ready/busy line reports busy.

Top module: `nand_seq`

## Requirements
- R1: Op code 0 (open-page read) emits command 00h with CLE high, then five ALE bytes in this order: column bits 7:0, column bits 11:8 (upper nibble zero), row bits 7:0, row bits 15:8, row bits 23:16. It ends with command 30h.
- R2: After the 30h or 10h confirm command, no WE# or RE# falling edge occurs while rb_n is low. The sequencer waits a guard time and then waits for rb_n high before the next bus phase.
- R3: A read delivers min(len, 2112 - col) bytes on rd_data, one RE# pulse each, in the order the device returns them starting at the requested column.
- R4: Op code 1 (column jump during read) emits command 05h, two column ALE bytes and command E0h. It does not wait on the busy line, then reads as in R3.
- R5: Op code 2 (open-page load) emits command 80h, the five address bytes of R1, then min(len, 2112 - col) data bytes. Each data byte is taken through a wr_valid/wr_ready transfer and written with CLE and ALE low, in arrival order.
- R6: Op code 3 (column jump during load) emits command 85h, two column ALE bytes, then data bytes as in R5, with the same clamp at the page end.
- R7: Op code 4 (commit) emits command 10h, waits as in R2, emits command 70h and reads one status byte. It then pulses op_done for exactly one cycle with op_fail equal to status bit 0. Every other operation ends with an op_done pulse and op_fail low.
- R8: WE# stays low for WE_LOW clock cycles and RE# stays low for RE_LOW clock cycles per pulse. WE# and RE# are never low together, CLE and ALE are never high together, and dq_oe is low whenever RE# is low.
- R9: After reset, ce_n, we_n and re_n are high, cle, ale, dq_oe, rd_valid and op_done are low, and req_ready is high.
- R10: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data stays unchanged.
- R11: req_ready is low from an accepted request until its op_done cycle, and a request offered in that window leaves no trace on the flash bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_op | input | 3 | Operation code (0..4, see R1-R7 rows) |
| req_col | input | 12 | Start column within the page |
| req_row | input | 24 | Row (page) address |
| req_len | input | 12 | Bytes to move |
| wr_valid | input | 1 | Load byte offered |
| wr_ready | output | 1 | Load byte taken |
| wr_data | input | 8 | Load byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| op_fail | output | 1 | Program status failure, valid with op_done |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| rb_n | input | 1 | Ready (high) / busy (low) from the device |
| dq_out | output | 8 | Byte driven toward the device |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 8 | Byte returned by the device |

## Verification
The hardest case to reach is the interaction between the busy window and a waiting requester. A new request must be refused, and no strobe may start, while the device holds rb_n low after a confirm command. The bench contains a behavioural flash model that pulls rb_n low shortly after it latches 30h or 10h and holds it for tens of cycles. During that window it offers a competing request and counts every strobe edge that falls while busy. Page-end clamping is reached by starting a column jump a few bytes before column 2111. Read back-pressure is reached by toggling rd_ready every cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_WR   = 2'd2,
        K_RD   = 2'd3
    } bus_kind_e;

    typedef enum logic [2:0] {
        OP_RD_PAGE   = 3'd0,
        OP_RD_JUMP   = 3'd1,
        OP_PG_LOAD   = 3'd2,
        OP_PG_JUMP   = 3'd3,
        OP_PG_COMMIT = 3'd4
    } seq_op_e;

    localparam logic [7:0] CMD_RD_OPEN   = 8'h00;
    localparam logic [7:0] CMD_RD_CONF   = 8'h30;
    localparam logic [7:0] CMD_RD_JUMP   = 8'h05;
    localparam logic [7:0] CMD_RD_JCONF  = 8'hE0;
    localparam logic [7:0] CMD_PG_OPEN   = 8'h80;
    localparam logic [7:0] CMD_PG_JUMP   = 8'h85;
    localparam logic [7:0] CMD_PG_CONF   = 8'h10;
    localparam logic [7:0] CMD_STATUS    = 8'h70;

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
    import nand_seq_pkg::*;
#(
    parameter int WE_LOW  = 2,
    parameter int WE_HIGH = 2,
    parameter int RE_LOW  = 2,
    parameter int RE_HIGH = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  bus_kind_e  kind,
    input  logic [7:0] dat,
    output logic       done,
    output logic [7:0] rdata,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    input  logic [7:0] dq_in
);
    localparam int MAX_A = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
    localparam int MAX_B = (RE_LOW > RE_HIGH) ? RE_LOW : RE_HIGH;
    localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAXC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

    typedef struct packed {
        ph_e             ph;
        bus_kind_e       kind;
        logic [7:0]      dat;
        logic [CW-1:0]   cnt;
        logic [7:0]      rdata;
        logic            done;
    } eng_s;

    eng_s e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        unique case (e_q.ph)
            PH_IDLE: if (go) begin
                e_d.ph   = PH_LOW;
                e_d.kind = kind;
                e_d.dat  = dat;
                e_d.cnt  = (kind == K_RD) ? CW'(RE_LOW - 1) : CW'(WE_LOW - 1);
            end
            PH_LOW: begin
                if (e_q.cnt == '0) begin
                    if (e_q.kind == K_RD) e_d.rdata = dq_in;
                    e_d.ph  = PH_HIGH;
                    e_d.cnt = (e_q.kind == K_RD) ? CW'(RE_HIGH - 1) : CW'(WE_HIGH - 1);
                end else begin
                    e_d.cnt = e_q.cnt - 1'b1;
                end
            end
            PH_HIGH: begin
                if (e_q.cnt == '0) begin
                    e_d.ph   = PH_IDLE;
                    e_d.done = 1'b1;
                end else begin
                    e_d.cnt = e_q.cnt - 1'b1;
                end
            end
            default: e_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{ph: PH_IDLE, kind: K_CMD, dat: 8'h00, cnt: '0, rdata: 8'h00, done: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign done   = e_q.done;
    assign rdata  = e_q.rdata;
    assign cle    = (e_q.ph != PH_IDLE) && (e_q.kind == K_CMD);
    assign ale    = (e_q.ph != PH_IDLE) && (e_q.kind == K_ADDR);
    assign we_n   = !((e_q.ph == PH_LOW) && (e_q.kind != K_RD));
    assign re_n   = !((e_q.ph == PH_LOW) && (e_q.kind == K_RD));
    assign dq_out = e_q.dat;
    assign dq_oe  = (e_q.ph != PH_IDLE) && (e_q.kind != K_RD);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    assert_latch_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
    assert_go_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (e_q.ph != PH_IDLE)) |-> 1'b0);

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 2112,
    parameter int COL_W      = 12,
    parameter int ROW_W      = 24,
    parameter int WE_LOW     = 2,
    parameter int WE_HIGH    = 2,
    parameter int RE_LOW     = 2,
    parameter int RE_HIGH    = 1,
    parameter int TWB_CYC    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [COL_W-1:0] req_col,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             op_done,
    output logic             op_fail,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    input  logic             rb_n,
    output logic [7:0]       dq_out,
    output logic             dq_oe,
    input  logic [7:0]       dq_in
);
    localparam int GW = $clog2(TWB_CYC + 1);
    localparam logic [COL_W-1:0] PAGE_C = COL_W'(PAGE_BYTES);

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_GUARD, S_WAIT,
        S_XFER, S_RHOLD, S_STAT_CMD, S_STAT_RD, S_DONE
    } st_e;

    typedef struct packed {
        st_e             st;
        seq_op_e         op;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] cnt;
        logic [2:0]      aidx;
        logic [GW-1:0]   gcnt;
        logic            sent;
        logic [7:0]      rdata;
        logic            fail;
    } seq_s;

    seq_s s_d, s_q;

    logic       go;
    bus_kind_e  go_kind;
    logic [7:0] go_dat;
    logic       eng_done;
    logic [7:0] eng_rdata;

    logic [2:0] n_addr;
    logic       is_read;
    logic [COL_W-1:0] avail;

    always_comb begin
        unique case (s_q.op)
            OP_RD_PAGE, OP_PG_LOAD: n_addr = 3'd5;
            OP_RD_JUMP, OP_PG_JUMP: n_addr = 3'd2;
            default:                n_addr = 3'd0;
        endcase
        is_read = (s_q.op == OP_RD_PAGE) || (s_q.op == OP_RD_JUMP);
        avail   = (req_col < PAGE_C) ? (PAGE_C - req_col) : '0;
    end

    always_comb begin
        s_d      = s_q;
        go       = 1'b0;
        go_kind  = K_CMD;
        go_dat   = 8'h00;
        wr_ready = 1'b0;

        unique case (s_q.st)
            S_IDLE: if (req_valid) begin
                s_d.st   = S_CMD1;
                s_d.op   = seq_op_e'(req_op);
                s_d.col  = req_col;
                s_d.row  = req_row;
                s_d.cnt  = (req_len > avail) ? avail : req_len;
                s_d.aidx = '0;
                s_d.sent = 1'b0;
                s_d.fail = 1'b0;
            end
            S_CMD1: begin
                go_kind = K_CMD;
                unique case (s_q.op)
                    OP_RD_PAGE: go_dat = CMD_RD_OPEN;
                    OP_RD_JUMP: go_dat = CMD_RD_JUMP;
                    OP_PG_LOAD: go_dat = CMD_PG_OPEN;
                    OP_PG_JUMP: go_dat = CMD_PG_JUMP;
                    default:    go_dat = CMD_PG_CONF;
                endcase
            end
            S_ADDR: begin
                go_kind = K_ADDR;
                unique case (s_q.aidx)
                    3'd0:    go_dat = s_q.col[7:0];
                    3'd1:    go_dat = 8'(s_q.col[COL_W-1:8]);
                    3'd2:    go_dat = s_q.row[7:0];
                    3'd3:    go_dat = s_q.row[15:8];
                    default: go_dat = s_q.row[23:16];
                endcase
            end
            S_CMD2: begin
                go_kind = K_CMD;
                go_dat  = (s_q.op == OP_RD_PAGE) ? CMD_RD_CONF : CMD_RD_JCONF;
            end
            S_GUARD: begin
                if (s_q.gcnt == '0) s_d.st = S_WAIT;
                else                s_d.gcnt = s_q.gcnt - 1'b1;
            end
            S_WAIT: if (rb_n) s_d.st = (s_q.op == OP_PG_COMMIT) ? S_STAT_CMD : S_XFER;
            S_XFER: begin
                go_kind = is_read ? K_RD : K_WR;
                go_dat  = wr_data;
                if (s_q.cnt == '0 && !s_q.sent) s_d.st = S_DONE;
                else if (!is_read) wr_ready = !s_q.sent && wr_valid && rb_n;
            end
            S_RHOLD: if (rd_ready) begin
                s_d.cnt = s_q.cnt - 1'b1;
                s_d.st  = S_XFER;
            end
            S_STAT_CMD: begin
                go_kind = K_CMD;
                go_dat  = CMD_STATUS;
            end
            S_STAT_RD: go_kind = K_RD;
            S_DONE:    s_d.st = S_IDLE;
            default:   s_d.st = S_IDLE;
        endcase

        // Launch one bus cycle per phase, only while the device is ready.
        if ((s_q.st inside {S_CMD1, S_ADDR, S_CMD2, S_STAT_CMD, S_STAT_RD} ||
             (s_q.st == S_XFER && s_q.cnt != '0)) && !s_q.sent && rb_n &&
            (s_q.st != S_XFER || is_read || wr_valid)) begin
            go       = 1'b1;
            s_d.sent = 1'b1;
        end

        if (eng_done) begin
            s_d.sent = 1'b0;
            unique case (s_q.st)
                S_CMD1: begin
                    if (n_addr != 3'd0)         s_d.st = S_ADDR;
                    else                        begin s_d.st = S_GUARD; s_d.gcnt = GW'(TWB_CYC); end
                end
                S_ADDR: begin
                    s_d.aidx = s_q.aidx + 1'b1;
                    if (s_q.aidx + 1'b1 == n_addr) s_d.st = is_read ? S_CMD2 : S_XFER;
                end
                S_CMD2: begin
                    if (s_q.op == OP_RD_PAGE) begin s_d.st = S_GUARD; s_d.gcnt = GW'(TWB_CYC); end
                    else                          s_d.st = S_XFER;
                end
                S_XFER: begin
                    if (is_read) begin
                        s_d.rdata = eng_rdata;
                        s_d.st    = S_RHOLD;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                S_STAT_CMD: s_d.st = S_STAT_RD;
                S_STAT_RD: begin
                    s_d.fail = eng_rdata[0];
                    s_d.st   = S_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, op: OP_RD_PAGE, col: '0, row: '0, cnt: '0,
                     aidx: '0, gcnt: '0, sent: 1'b0, rdata: 8'h00, fail: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    nand_bus_cycle #(
        .WE_LOW (WE_LOW),
        .WE_HIGH(WE_HIGH),
        .RE_LOW (RE_LOW),
        .RE_HIGH(RE_HIGH)
    ) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .kind  (go_kind),
        .dat   (go_dat),
        .done  (eng_done),
        .rdata (eng_rdata),
        .cle   (cle),
        .ale   (ale),
        .we_n  (we_n),
        .re_n  (re_n),
        .dq_out(dq_out),
        .dq_oe (dq_oe),
        .dq_in (dq_in)
    );

    assign req_ready = (s_q.st == S_IDLE);
    assign rd_valid  = (s_q.st == S_RHOLD);
    assign rd_data   = s_q.rdata;
    assign op_done   = (s_q.st == S_DONE);
    assign op_fail   = (s_q.st == S_DONE) && s_q.fail;
    assign ce_n      = (s_q.st == S_IDLE);

    assert_gate_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> rb_n);
    assert_hold_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    assert_busy_refuse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    assert_fail_only_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_fail |-> op_done);

endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [11:0] req_col = '0;
    logic [23:0] req_row = '0;
    logic [11:0] req_len = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        op_done, op_fail, ce_n, cle, ale, we_n, re_n;
    logic        rb_n;
    logic [7:0]  dq_out, dq_in;
    logic        dq_oe;

    nand_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_col(req_col), .req_row(req_row), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .op_done(op_done), .op_fail(op_fail), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .rb_n(rb_n), .dq_out(dq_out), .dq_oe(dq_oe),
        .dq_in(dq_in)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural flash model ----------------
    logic [9:0]  lkind [0:255];
    logic [7:0]  lbyte [0:255];
    int          lidx = 0;
    logic [7:0]  pg [0:2111];
    logic [11:0] base = '0;
    int          rd_adv = 0;
    int          rd_mark = 0;
    int          aidx_m = 0;
    bit          stat_mode = 1'b0;
    bit          fail_next = 1'b0;
    bit          busy_req = 1'b0;
    bit          busy_ack = 1'b0;
    int          busy_cnt = 0;
    int          busy_seen = 0;
    logic [11:0] eff;

    assign rb_n = (busy_cnt == 0);
    assign eff  = base + 12'(rd_adv - rd_mark);
    assign dq_in = stat_mode ? {7'b1100000, fail_next} : (eff[7:0] ^ 8'h5A);

    always @(posedge we_n) begin
        if (cle) begin
            lkind[lidx] = 10'd1; lbyte[lidx] = dq_out; lidx++;
            aidx_m    = 0;
            stat_mode = (dq_out == 8'h70);
            if (dq_out == 8'h30 || dq_out == 8'h10) busy_req = ~busy_req;
        end else if (ale) begin
            lkind[lidx] = 10'd2; lbyte[lidx] = dq_out; lidx++;
            if (aidx_m == 0) base[7:0] = dq_out;
            if (aidx_m == 1) base[11:8] = dq_out[3:0];
            rd_mark = rd_adv;
            aidx_m++;
        end else begin
            lkind[lidx] = 10'd3; lbyte[lidx] = dq_out; lidx++;
            if (base < 12'd2112) pg[base] = dq_out;
            base = base + 12'd1;
        end
    end

    always @(posedge re_n) rd_adv++;

    always @(posedge clk) begin
        if (busy_req != busy_ack) begin
            busy_ack <= busy_req;
            busy_cnt <= 40;
            busy_seen <= busy_seen + 1;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    // ---------------- stream agents ----------------
    int         wr_idx = 0;
    logic [7:0] wr_seed = 8'hA0;
    assign wr_data = wr_seed + 8'(wr_idx);
    always @(posedge clk) if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;

    logic [7:0] rbuf [0:255];
    int         rcount = 0;
    bit         stall_mode = 1'b0;
    always @(posedge clk) begin
        if (rd_valid && rd_ready) begin
            rbuf[rcount] <= rd_data;
            rcount <= rcount + 1;
        end
        rd_ready <= stall_mode ? ~rd_ready : 1'b1;
    end

    // ---------------- monitors ----------------
    int viol = 0;
    int we_w = 0, re_w = 0;
    int we_min = 99, we_max = 0, re_min = 99, re_max = 0;
    logic we_p = 1'b1, re_p = 1'b1;
    int hold_bad = 0;
    bit hold_arm = 1'b0;
    logic [7:0] hold_val = '0;
    always @(negedge clk) begin
        if ((we_p && !we_n) || (re_p && !re_n)) if (!rb_n) viol++;
        we_p = we_n; re_p = re_n;
        if (!we_n) we_w++;
        else if (we_w != 0) begin
            if (we_w < we_min) we_min = we_w;
            if (we_w > we_max) we_max = we_w;
            we_w = 0;
        end
        if (!re_n) re_w++;
        else if (re_w != 0) begin
            if (re_w < re_min) re_min = re_w;
            if (re_w > re_max) re_max = re_w;
            re_w = 0;
        end
        if (hold_arm && !(rd_valid && rd_data == hold_val)) hold_bad++;
        hold_arm = rd_valid && !rd_ready;
        hold_val = rd_data;
    end

    // ---------------- helpers ----------------
    task automatic start_op(input logic [2:0] op, input logic [11:0] col,
                            input logic [23:0] row, input logic [11:0] len);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_col = col; req_row = row; req_len = len; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit fail);
        fail = 1'b0;
        while (!op_done) @(negedge clk);
        fail = op_fail;
        @(negedge clk);
    endtask

    task automatic expect_log(input int mark, input int pos, input int k,
                              input logic [7:0] b, input string tag);
        check(lkind[mark+pos] == 10'(k) && lbyte[mark+pos] == b, tag,
              {lkind[mark+pos][7:0], lbyte[mark+pos]}, {k[7:0], b});
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(ce_n && we_n && re_n, "R9 strobes idle", {ce_n, we_n, re_n}, 3'b111);
        check(!cle && !ale && !dq_oe, "R9 latches low", {cle, ale, dq_oe}, 0);
        check(req_ready && !rd_valid && !op_done, "R9 handshake", {req_ready, rd_valid, op_done}, 3'b100);
    endtask

    task automatic t_read_page();
        int m = lidx; int r = rcount; int bs = busy_seen; bit f; bit saw_ready = 1'b0;
        start_op(3'd0, 12'd5, 24'h030201, 12'd8);
        for (int i = 0; i < 30; i++) begin
            if (req_ready) saw_ready = 1'b1;
            if (i == 20) req_valid = 1'b1;
            if (i == 20) req_op = 3'd4;
            @(negedge clk);
            req_valid = 1'b0;
        end
        check(!saw_ready, "R11 req_ready low during op", saw_ready, 0);
        wait_done(f);
        expect_log(m, 0, 1, 8'h00, "R1 cmd 00");
        expect_log(m, 1, 2, 8'h05, "R1 col lo");
        expect_log(m, 2, 2, 8'h00, "R1 col hi");
        expect_log(m, 3, 2, 8'h01, "R1 row lo");
        expect_log(m, 4, 2, 8'h02, "R1 row mid");
        expect_log(m, 5, 2, 8'h03, "R1 row hi");
        expect_log(m, 6, 1, 8'h30, "R1 cmd 30");
        check(lidx - m == 7, "R11 no extra bus traffic", lidx - m, 7);
        check(busy_seen - bs == 1, "R2 busy window seen", busy_seen - bs, 1);
        check(rcount - r == 8, "R3 read count", rcount - r, 8);
        for (int i = 0; i < 8; i++)
            check(rbuf[r+i] == (8'(5 + i) ^ 8'h5A), "R3 read data", rbuf[r+i], (8'(5 + i) ^ 8'h5A));
        check(!f, "R7 op_fail low on read", f, 0);
        @(negedge clk);
        check(req_ready, "R11 ready after done", req_ready, 1);
    endtask

    task automatic t_read_jump();
        int m = lidx; int r = rcount; int bs = busy_seen; bit f;
        stall_mode = 1'b1;
        start_op(3'd1, 12'd300, 24'h0, 12'd4);
        wait_done(f);
        stall_mode = 1'b0;
        expect_log(m, 0, 1, 8'h05, "R4 cmd 05");
        expect_log(m, 1, 2, 8'h2C, "R4 col lo");
        expect_log(m, 2, 2, 8'h01, "R4 col hi");
        expect_log(m, 3, 1, 8'hE0, "R4 cmd E0");
        check(busy_seen == bs, "R4 no busy wait", busy_seen - bs, 0);
        check(rcount - r == 4, "R4 read count", rcount - r, 4);
        for (int i = 0; i < 4; i++)
            check(rbuf[r+i] == (8'(300 + i) ^ 8'h5A), "R4 read data", rbuf[r+i], (8'(300 + i) ^ 8'h5A));
        check(hold_bad == 0, "R10 stall hold", hold_bad, 0);
    endtask

    task automatic t_read_clamp();
        int r = rcount; bit f;
        start_op(3'd1, 12'd2108, 24'h0, 12'd10);
        wait_done(f);
        check(rcount - r == 4, "R3 clamp at page end", rcount - r, 4);
        check(rbuf[r+3] == (8'(2111) ^ 8'h5A), "R3 last column byte", rbuf[r+3], (8'(2111) ^ 8'h5A));
    endtask

    task automatic t_prog();
        int m = lidx; int w0; bit f;
        wr_valid = 1'b1;
        w0 = wr_idx;
        start_op(3'd2, 12'd10, 24'h000102, 12'd3);
        wait_done(f);
        expect_log(m, 0, 1, 8'h80, "R5 cmd 80");
        expect_log(m, 1, 2, 8'h0A, "R5 col lo");
        expect_log(m, 3, 2, 8'h02, "R5 row lo");
        expect_log(m, 4, 2, 8'h01, "R5 row mid");
        expect_log(m, 6, 3, 8'(8'hA0 + w0), "R5 first data");
        for (int i = 0; i < 3; i++)
            check(pg[10+i] == 8'(8'hA0 + w0 + i), "R5 loaded byte", pg[10+i], 8'(8'hA0 + w0 + i));
        check(lidx - m == 9, "R5 cycle count", lidx - m, 9);
        m = lidx; w0 = wr_idx;
        start_op(3'd3, 12'd2000, 24'h0, 12'd2);
        wait_done(f);
        expect_log(m, 0, 1, 8'h85, "R6 cmd 85");
        expect_log(m, 1, 2, 8'hD0, "R6 col lo");
        expect_log(m, 2, 2, 8'h07, "R6 col hi");
        for (int i = 0; i < 2; i++)
            check(pg[2000+i] == 8'(8'hA0 + w0 + i), "R6 jump byte", pg[2000+i], 8'(8'hA0 + w0 + i));
        m = lidx;
        start_op(3'd3, 12'd2111, 24'h0, 12'd3);
        wait_done(f);
        check(lidx - m == 4, "R6 clamp at page end", lidx - m, 4);
        wr_valid = 1'b0;
    endtask

    task automatic t_commit(input bit fl);
        int m = lidx; int bs = busy_seen; bit f;
        fail_next = fl;
        start_op(3'd4, 12'd0, 24'h0, 12'd0);
        wait_done(f);
        expect_log(m, 0, 1, 8'h10, "R7 cmd 10");
        expect_log(m, 1, 1, 8'h70, "R7 cmd 70");
        check(busy_seen - bs == 1, "R2 commit busy", busy_seen - bs, 1);
        check(f == fl, "R7 status bit", f, fl);
    endtask

    // ---------------- watchdog and main ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_page();
        t_read_jump();
        t_read_clamp();
        t_prog();
        t_commit(1'b0);
        t_commit(1'b1);
        check(viol == 0, "R2 no strobe while busy", viol, 0);
        check(we_min == 2 && we_max == 2, "R8 WE# width", {we_min[7:0], we_max[7:0]}, 16'h0202);
        check(re_min == 2 && re_max == 2, "R8 RE# width", {re_min[7:0], re_max[7:0]}, 16'h0202);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule